// File: doc/BRIEF.md
# Oversampling Receive Clock and Data Recovery Loop

This block recovers a bit-rate receive clock and the received bit from a serial differential-receiver output. It runs on a local clock four times the nominal bit rate, for example 48 MHz for a 12 Mb/s line. It samples the incoming line on both edges of that clock. It first acquires phase from the opening transitions of a packet. After that, each bit period is a four-state lap: one lap is used while the line is high and a mirror lap while it is low. On every transition the phase is corrected by up to one oversampling cycle, in either direction, so that a bit-rate offset between transmitter and receiver is absorbed.

The loop state is a four-bit code in which bit 2 always carries the data level. The recovered clock, the data level, a lock flag and a one-cycle bit strobe are all driven from flops in the oversampling clock domain. A downstream NRZI decoder or sync detector can therefore use the strobe as a clock enable. Those consumers must ignore the data whenever the lock flag is low. Reset, or a low receive-enable, returns the loop to acquisition. Lock is then regained only after two fresh line transitions.

Top module: `rx_clock_recovery`

## Requirements
- R1: With `rst` high, or `rx_en` low, at a rising clock edge, the loop returns to the first acquire code 12 at that edge. `lock_o`, `rclk_o` and `bit_stb_o` are 0 after it, and `bit_o`/`rdat_o` reset to 0 under `rst`.
- R2: A qualified transition moves the first acquire code 12 to the second acquire code 13. A second qualified transition moves code 13 into the lap entry for the current level: code 5 when the level is 1, code 1 when it is 0. `lock_o` rises after that same edge. A qualified transition is seen when the rising-edge sample differs from the newest falling-edge sample, or when two successive falling-edge samples differ. A line change driven between rising edges n-1 and n is consumed at edge n.
- R3: While fewer than two qualified transitions have arrived, `lock_o` and `rclk_o` stay 0 however long the line is held.
- R4: Laps run 5→7→6→4 for level 1 and 1→3→2→0 for level 0. `rclk_o` is 1 in the inner codes 7, 6, 3, 2 and in the long-bit codes 15 and 11. It is 0 in the outer codes. Bits of four cycles give two cycles high, two cycles low, and one strobe per four cycles.
- R5: `rdat_o` equals bit 2 of the loop code after each edge. It is 1 in codes 4–7, 12, 13 and 15, and 0 in codes 0–3 and 11. It therefore reads 1 while unlocked.
- R6: At the exit codes 4 and 0, the loop enters the lap for the sampled level (code 5 or code 1). At codes 6 and 2, a level opposite to the lap moves straight to the other lap's entry. This shortens the following clock-low time to one cycle.
- R7: At codes 7 and 3, a level opposite to the lap detours through code 11 (from 7) or code 15 (from 3) to code 2 or code 6. This stretches that clock-high time to three cycles.
- R8: `bit_stb_o` is 1 exactly in the first cycle that `rclk_o` is 0 after being 1. In that cycle, `bit_o` is bit 2 of the last high code, which is the recovered bit. Strobes are never in adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, four times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; low forces acquisition |
| rxd | input | 1 | Differential receiver output |
| rclk_o | output | 1 | Registered recovered bit clock level |
| rdat_o | output | 1 | Registered data level (bit 2 of loop code) |
| bit_stb_o | output | 1 | One-cycle strobe per recovered bit |
| bit_o | output | 1 | Recovered bit, valid with the strobe |
| lock_o | output | 1 | Loop has left acquisition |

## Verification
All outputs are flops loaded from the next loop code. A line level driven just after rising edge n-1 is captured at the falling edge and consumed at edge n, and every output shows its effect right after edge n. The bench drives the line 1 ns after each rising edge and samples the outputs 1 ns after the next rising edge. It advances its own transition-table model at that same edge and compares every output in every cycle. Run lengths and strobe counts are taken from the outputs across whole four-cycle windows. The first partial high or low run in a window is dropped, so phase at the window start never biases the short-bit and long-bit checks.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

    // Loop codes; bit 2 of each code is the data level
    typedef enum logic [3:0] {
        PH_L_EXIT = 4'h0,
        PH_L_ENT  = 4'h1,
        PH_L_DN   = 4'h2,
        PH_L_UP   = 4'h3,
        PH_H_EXIT = 4'h4,
        PH_H_ENT  = 4'h5,
        PH_H_DN   = 4'h6,
        PH_H_UP   = 4'h7,
        PH_LONG_L = 4'hB,
        PH_ACQ0   = 4'hC,
        PH_ACQ1   = 4'hD,
        PH_LONG_H = 4'hF
    } phase_e;

    localparam int unsigned DATA_BIT = 2;

    typedef struct packed {
        logic lvl;   // newest falling-edge sample
        logic chg;   // qualified transition
    } line_s;

    typedef struct packed {
        logic rclk;
        logic rdat;
        logic stb;
        logic bitv;
        logic lock;
    } rec_out_s;

    function automatic logic ph_high(input phase_e p);
        case (p)
            PH_H_UP, PH_H_DN, PH_L_UP, PH_L_DN, PH_LONG_H, PH_LONG_L: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic ph_locked(input phase_e p);
        return (p != PH_ACQ0) && (p != PH_ACQ1);
    endfunction

    function automatic phase_e ph_entry(input logic lvl);
        return lvl ? PH_H_ENT : PH_L_ENT;
    endfunction

endpackage

// File: rtl/dpll_line_sampler.sv
module dpll_line_sampler
    import dpll_pkg::*;
#(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  rxd,
    output line_s smp
);
    logic fall_q;    // sampled on falling edge
    logic rise_q;    // sampled on rising edge
    logic fall_pq;   // previous falling sample

    always_ff @(negedge clk) begin
        if (rst) fall_q <= IDLE_LVL;
        else     fall_q <= rxd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_q  <= IDLE_LVL;
            fall_pq <= IDLE_LVL;
        end else begin
            rise_q  <= rxd;
            fall_pq <= fall_q;
        end
    end

    always_comb begin
        smp.lvl = fall_q;
        smp.chg = (rise_q != fall_q) || (fall_q != fall_pq);
    end
endmodule

// File: rtl/dpll_phase_fsm.sv
module dpll_phase_fsm
    import dpll_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rx_en,
    input  line_s  smp,
    output phase_e st_q,
    output phase_e st_nxt
);
    always_comb begin
        st_nxt = st_q;
        if (!rx_en) begin
            st_nxt = PH_ACQ0;
        end else begin
            case (st_q)
                PH_ACQ0:   if (smp.chg) st_nxt = PH_ACQ1;
                PH_ACQ1:   if (smp.chg) st_nxt = ph_entry(smp.lvl);
                PH_H_ENT:  st_nxt = PH_H_UP;
                PH_L_ENT:  st_nxt = PH_L_UP;
                PH_H_UP:   st_nxt = smp.lvl ? PH_H_DN : PH_LONG_L;
                PH_L_UP:   st_nxt = smp.lvl ? PH_LONG_H : PH_L_DN;
                PH_LONG_L: st_nxt = PH_L_DN;
                PH_LONG_H: st_nxt = PH_H_DN;
                PH_H_DN:   st_nxt = smp.lvl ? PH_H_EXIT : PH_L_ENT;
                PH_L_DN:   st_nxt = smp.lvl ? PH_H_ENT : PH_L_EXIT;
                PH_H_EXIT, PH_L_EXIT: st_nxt = ph_entry(smp.lvl);
                default:   st_nxt = PH_ACQ0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= PH_ACQ0;
        else     st_q <= st_nxt;
    end

    AST_RX_OFF: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (st_q == PH_ACQ0)); // R1
    AST_ACQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_ACQ0) |=> (st_q == PH_ACQ0 || st_q == PH_ACQ1)); // R3
    AST_LONG_H_NEXT: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_LONG_H) |=> (st_q == PH_H_DN || st_q == PH_ACQ0)); // R7
    AST_LONG_L_NEXT: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_LONG_L) |=> (st_q == PH_L_DN || st_q == PH_ACQ0)); // R7
endmodule

// File: rtl/dpll_out_reg.sv
module dpll_out_reg
    import dpll_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  phase_e   st_q,
    input  phase_e   st_nxt,
    output rec_out_s ro
);
    logic falling;
    assign falling = ph_high(st_q) && !ph_high(st_nxt);

    always_ff @(posedge clk) begin
        if (rst) begin
            ro <= '0;
        end else begin
            ro.rclk <= ph_high(st_nxt);
            ro.rdat <= st_nxt[DATA_BIT];
            ro.lock <= ph_locked(st_nxt);
            ro.stb  <= falling;
            if (falling) ro.bitv <= st_q[DATA_BIT];
        end
    end

    AST_STB_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        ro.stb |-> (!ro.rclk && $past(ro.rclk))); // R8
    AST_STB_SPACED: assert property (@(posedge clk) disable iff (rst)
        ro.stb |=> !ro.stb); // R8
    AST_NO_CLK_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        !ro.lock |-> !ro.rclk); // R3
    AST_HIGH_MAX: assert property (@(posedge clk) disable iff (rst)
        (ro.rclk && $past(ro.rclk) && $past(ro.rclk, 2)) |=> !ro.rclk); // R7
endmodule

// File: rtl/rx_clock_recovery.sv
module rx_clock_recovery
    import dpll_pkg::*;
#(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_en,
    input  logic rxd,
    output logic rclk_o,
    output logic rdat_o,
    output logic bit_stb_o,
    output logic bit_o,
    output logic lock_o
);
    line_s    smp;
    phase_e   st_q;
    phase_e   st_nxt;
    rec_out_s ro;

    dpll_line_sampler #(.IDLE_LVL(IDLE_LVL)) u_smp (
        .clk (clk),
        .rst (rst),
        .rxd (rxd),
        .smp (smp)
    );

    dpll_phase_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .rx_en  (rx_en),
        .smp    (smp),
        .st_q   (st_q),
        .st_nxt (st_nxt)
    );

    dpll_out_reg u_out (
        .clk    (clk),
        .rst    (rst),
        .st_q   (st_q),
        .st_nxt (st_nxt),
        .ro     (ro)
    );

    assign rclk_o    = ro.rclk;
    assign rdat_o    = ro.rdat;
    assign bit_stb_o = ro.stb;
    assign bit_o     = ro.bitv;
    assign lock_o    = ro.lock;
endmodule

// File: tb/rx_clock_recovery_tb.sv
module rx_clock_recovery_tb;
    localparam int CLK_P = 20;
    localparam int SEED  = 32'h1d2c3b4a;

    logic clk = 1'b0;
    logic rst, rx_en, rxd;
    logic rclk_o, rdat_o, bit_stb_o, bit_o, lock_o;

    always #(CLK_P/2) clk = ~clk;

    rx_clock_recovery u_dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .rxd(rxd),
        .rclk_o(rclk_o), .rdat_o(rdat_o), .bit_stb_o(bit_stb_o),
        .bit_o(bit_o), .lock_o(lock_o)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // bench view of the applied inputs
    logic cur_line, prev_line, cur_en, cur_rst;
    // reference model
    logic [3:0] m_st;
    logic e_rclk, e_rdat, e_lock, e_stb, e_bit;
    // observation trackers
    int  stb_cnt, min_lo, max_hi, hi_len, lo_len, alt_err;
    bit  started, any_hi, have_prev;
    logic last_rclk, prev_bit;

    function automatic logic [3:0] ref_next(logic [3:0] s, logic en, logic l, logic c);
        if (!en) return 4'hC;
        case (s)
            4'hC: return c ? 4'hD : 4'hC;
            4'hD: return c ? (l ? 4'h5 : 4'h1) : 4'hD;
            4'h5: return 4'h7;
            4'h1: return 4'h3;
            4'h7: return l ? 4'h6 : 4'hB;
            4'h3: return l ? 4'hF : 4'h2;
            4'hB: return 4'h2;
            4'hF: return 4'h6;
            4'h6: return l ? 4'h4 : 4'h1;
            4'h2: return l ? 4'h5 : 4'h0;
            4'h4, 4'h0: return l ? 4'h5 : 4'h1;
            default: return 4'hC;
        endcase
    endfunction

    function automatic logic ref_high(logic [3:0] s);
        return (s == 4'h7) || (s == 4'h6) || (s == 4'h3) || (s == 4'h2) ||
               (s == 4'hF) || (s == 4'hB);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic clear_stats();
        stb_cnt = 0; min_lo = 99; max_hi = 0; hi_len = 0; lo_len = 0;
        started = 1'b0; alt_err = 0; have_prev = 1'b0;
    endtask

    // one clock: model the edge, compare, then drive the next inputs
    task automatic tick(input logic nl, input logic nen, input logic nrst);
        logic [3:0] m_prev;
        @(posedge clk);
        #1;
        if (cur_rst) begin
            m_st = 4'hC;
            {e_rclk, e_rdat, e_lock, e_stb, e_bit} = '0;
        end else begin
            m_prev = m_st;
            m_st   = ref_next(m_st, cur_en, cur_line, cur_line != prev_line);
            e_rclk = ref_high(m_st);
            e_rdat = m_st[2];
            e_lock = (m_st != 4'hC) && (m_st != 4'hD);
            e_stb  = ref_high(m_prev) && !ref_high(m_st);
            if (e_stb) e_bit = m_prev[2];
        end
        chk(rclk_o === e_rclk, "R4 rclk", int'(rclk_o), int'(e_rclk));
        chk(rdat_o === e_rdat, "R5 rdat", int'(rdat_o), int'(e_rdat));
        chk(lock_o === e_lock, "R2 lock", int'(lock_o), int'(e_lock));
        chk(bit_stb_o === e_stb, "R8 strobe", int'(bit_stb_o), int'(e_stb));
        if (e_stb) chk(bit_o === e_bit, "R8 bit", int'(bit_o), int'(e_bit));
        // trackers from the ports
        if (rclk_o) any_hi = 1'b1;
        if (bit_stb_o) begin
            stb_cnt++;
            if (have_prev && bit_o == prev_bit) alt_err++;
            prev_bit = bit_o; have_prev = 1'b1;
        end
        if (rclk_o !== last_rclk) begin
            if (started) begin
                if (last_rclk) max_hi = (hi_len > max_hi) ? hi_len : max_hi;
                else           min_lo = (lo_len < min_lo) ? lo_len : min_lo;
            end
            started = 1'b1; hi_len = 0; lo_len = 0;
        end
        if (rclk_o) hi_len++; else lo_len++;
        last_rclk = rclk_o;
        prev_line = cur_line;
        cur_line = nl;  rxd   = nl;
        cur_en   = nen; rx_en = nen;
        cur_rst  = nrst; rst  = nrst;
    endtask

    task automatic level(input logic v, input int len);
        for (int i = 0; i < len; i++) tick(v, 1'b1, 1'b0);
    endtask

    initial begin
        int r;
        logic v;
        r = $urandom(SEED);
        rst = 1'b1; rx_en = 1'b1; rxd = 1'b1;
        cur_rst = 1'b1; cur_en = 1'b1; cur_line = 1'b1; prev_line = 1'b1;
        m_st = 4'hC; last_rclk = 1'b0; any_hi = 1'b0; prev_bit = 1'b0;
        clear_stats();
        repeat (3) tick(1'b1, 1'b1, 1'b1);
        tick(1'b1, 1'b1, 1'b0);
        // R1: reset values
        chk(lock_o === 1'b0 && rclk_o === 1'b0 && bit_stb_o === 1'b0 && bit_o === 1'b0,
            "R1 reset outputs", int'({lock_o, rclk_o, bit_stb_o, bit_o}), 0);
        tick(1'b1, 1'b1, 1'b0);
        // R3: one transition only, held for a long time
        any_hi = 1'b0;
        tick(1'b0, 1'b1, 1'b0);
        repeat (30) tick(1'b0, 1'b1, 1'b0);
        chk(lock_o === 1'b0, "R3 no lock on one edge", int'(lock_o), 0);
        chk(any_hi == 1'b0, "R3 no clock on one edge", int'(any_hi), 0);
        // R2: second transition locks into the level-1 lap
        tick(1'b1, 1'b1, 1'b0);
        tick(1'b1, 1'b1, 1'b0);
        chk(lock_o === 1'b1, "R2 lock after second edge", int'(lock_o), 1);
        chk(rdat_o === 1'b1 && rclk_o === 1'b0, "R2 entry code 5",
            int'({rdat_o, rclk_o}), 2);
        level(1'b1, 2);
        // R4: nominal four-cycle bits
        v = 1'b0;
        for (int b = 0; b < 2; b++) begin level(v, 4); v = ~v; end
        clear_stats();
        for (int b = 0; b < 10; b++) begin level(v, 4); v = ~v; end
        chk(stb_cnt == 10, "R4 strobes per 40 cycles", stb_cnt, 10);
        chk(min_lo == 2, "R4 low time", min_lo, 2);
        chk(max_hi == 2, "R4 high time", max_hi, 2);
        chk(alt_err == 0, "R8 alternating bits", alt_err, 0);
        // R6: one short bit
        clear_stats();
        level(v, 4); v = ~v; level(v, 3); v = ~v;
        for (int b = 0; b < 3; b++) begin level(v, 4); v = ~v; end
        chk(min_lo == 1, "R6 shortened low", min_lo, 1);
        // R7: one long bit
        clear_stats();
        level(v, 4); v = ~v; level(v, 5); v = ~v;
        for (int b = 0; b < 3; b++) begin level(v, 4); v = ~v; end
        chk(max_hi == 3, "R7 stretched high", max_hi, 3);
        // R5: level-0 lap reads 0 on the data level output
        level(1'b0, 2);
        chk(rdat_o === 1'b0, "R5 data level in 0 lap", int'(rdat_o), 0);
        level(1'b0, 2);
        // R1: receive enable dropped mid-stream
        tick(1'b1, 1'b0, 1'b0);
        tick(1'b1, 1'b0, 1'b0);
        chk(lock_o === 1'b0 && rclk_o === 1'b0, "R1 rx_en low clears lock",
            int'({lock_o, rclk_o}), 0);
        tick(1'b1, 1'b1, 1'b0);
        // random bit stream with occasional disruptions
        v = 1'b1;
        for (int b = 0; b < 3000; b++) begin
            int len, pick;
            pick = $urandom_range(0, 99);
            if (pick < 12)      len = 3;
            else if (pick < 24) len = 5;
            else if (pick < 26) len = 1;
            else                len = 4;
            if ($urandom_range(0, 1) == 1) v = ~v;
            if ($urandom_range(0, 299) == 0) begin
                repeat (3) tick(v, 1'b0, 1'b0);
            end else if ($urandom_range(0, 499) == 0) begin
                repeat (2) tick(1'b1, 1'b1, 1'b1);
                tick(1'b1, 1'b1, 1'b0);
            end
            level(v, len);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule